// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block supervises software liveness. A counter of `CNT_W` bits (16 by default) advances once per prescaler tick. If it wraps past its all-ones value before software services it, the block raises a reset request for one clock and counts again from zero. The system reset generator that consumes this request lies outside the block. A programmable prescaler divides the clock by 2^e, with e from 0 to 7, ahead of the counter. This lets software lengthen the time allowed between services.

Software reaches the block through a plain register write port: an address, a data byte and a one-cycle strobe. Every strobed write is taken in the cycle it is presented. There is no back-pressure, and the port has no read side. The configuration register holds the prescale exponent and a disable bit, so software can turn the watchdog off completely. Service is a two-write unlock sequence on a separate clear register, which makes it unlikely that runaway code services the watchdog by accident.

Top module: `wdog_prescaled`

## Requirements
- R1: While `rst_n` is low, `rst_req` is low. After reset the watchdog is enabled with exponent 0, so the first request comes 2^CNT_W cycles after the last clock edge at which reset was held.
- R2: Writing byte d to offset 0Dh sets the exponent e = d[2:0]. After a valid clear, `rst_req` rises exactly 2^(CNT_W+e) cycles after the clock edge that took the clearing write.
- R3: `rst_req` is high for exactly one cycle. Counting then restarts from zero, so the next request follows 2^(CNT_W+e) cycles after the overflowing edge.
- R4: A valid clear is a write of 1Eh to offset 0Ah followed, as the very next strobed write, by a write of E1h to offset 0Ah. It zeroes both the counter and the prescaler divider.
- R5: Every other sequence leaves the counter and divider unchanged. This covers E1h without a preceding 1Eh, a wrong data byte at 0Ah after 1Eh, and any write to another offset between the two keys.
- R6: While bit 7 of the configuration byte is set, the watchdog is disabled and `rst_req` stays low however long software waits.
- R7: A configuration write with bit 7 clear re-enables the watchdog with the counter and divider zeroed. The next request comes 2^(CNT_W+e) cycles after that write's edge.
- R8: A valid clear taken on the same edge as an overflowing tick wins. No request is raised, and a full period starts from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 8 | Register offset (0Dh configuration, 0Ah clear) |
| wr_data | input | 8 | Write data byte |
| rst_req | output | 1 | One-cycle reset request on counter overflow |

## Verification
The assertions assume that software uses the write port only as specified: each strobe is one complete write, and the key sequence counts only strobed cycles. The bound checker rebuilds the armed and disabled state from the port traffic alone. The stimulus therefore always drives `wr_en` for exactly one cycle per write and keeps the address and data stable around the sampling edge. The bench runs with a narrow counter so that every exponent, including 7, reaches overflow several times within the run. The unlock corner cases are placed early in a period so that they cannot collide with an overflow, except in the one test that aims a clear exactly at the overflowing edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned EXP_W    = 3;
  localparam int unsigned DIS_BIT  = 7;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 8'h0D;
  localparam logic [ADDR_W-1:0] KICK_ADDR = 8'h0A;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h1E;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hE1;

  typedef enum logic {
    UNLK_IDLE  = 1'b0,
    UNLK_ARMED = 1'b1
  } unlock_t;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              kick
);
  unlock_t state_q;
  logic    hit_clr;

  assign hit_clr = wr_en && (wr_addr == KICK_ADDR);
  // R4: second key accepted only directly after the first
  assign kick    = hit_clr && (wr_data == KEY_SECOND) && (state_q == UNLK_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= UNLK_IDLE;
    end else if (wr_en) begin
      // R5: any strobed write other than the first key disarms
      state_q <= (hit_clr && (wr_data == KEY_FIRST)) ? UNLK_ARMED : UNLK_IDLE;
    end
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int unsigned XW = EXP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [XW-1:0] expo,
  output logic          tick
);
  localparam int unsigned DIV_W = (1 << XW) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(expo));
    end
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic req
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top = &cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else begin
      // R8: a clear on the overflow edge suppresses the request
      req <= run && !restart && tick && at_top;
    end
  end
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        rst_req
);
  logic [EXP_W-1:0] expo_q;
  logic             dis_q;
  logic             kick;
  logic             tick;
  logic             run;

  // R1, R2, R6, R7: configuration register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expo_q <= '0;
      dis_q  <= 1'b0;
    end else if (wr_en && (wr_addr == CFG_ADDR)) begin
      expo_q <= wr_data[EXP_W-1:0];
      dis_q  <= wr_data[DIS_BIT];
    end
  end

  assign run = !dis_q;

  wdog_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .kick    (kick)
  );

  wdog_prescale #(.XW(EXP_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (kick),
    .expo    (expo_q),
    .tick    (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (kick),
    .tick    (tick),
    .req     (rst_req)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       rst_req
);
  localparam int unsigned GAP_W = CNT_W + (1 << EXP_W) + 1;
  localparam logic [GAP_W-1:0] MIN_GAP = GAP_W'(1) << CNT_W;

  logic             armed_sh;
  logic             dis_sh;
  logic             kick_ev;
  logic [GAP_W-1:0] gap;

  assign kick_ev = wr_en && (wr_addr == 8'h0A) && (wr_data == 8'hE1) && armed_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_sh <= 1'b0;
      dis_sh   <= 1'b0;
      gap      <= '0;
    end else begin
      if (wr_en) armed_sh <= (wr_addr == 8'h0A) && (wr_data == 8'h1E);
      if (wr_en && (wr_addr == 8'h0D)) dis_sh <= wr_data[7];
      if (kick_ev || dis_sh)  gap <= '0;
      else if (rst_req)       gap <= GAP_W'(1);
      else if (gap != '1)     gap <= gap + 1'b1;
    end
  end

  // R3: request lasts exactly one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R2: no request sooner than one full period at the fastest rate
  a_r2_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (gap >= MIN_GAP));

  // R6: silent while disabled
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_sh && $past(dis_sh)) |-> !rst_req);

  // R8: a valid clear is never followed by a request
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ev |=> !rst_req);
endmodule

bind wdog_prescaled wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rst_req (rst_req)
);

// File: tb/wdog_prescaled_tb.sv
module wdog_prescaled_tb;
  localparam int unsigned CW = 6;
  localparam int unsigned NV = 5;
  localparam int unsigned VEC_EXP [NV] = '{0, 2, 3, 5, 7};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rst_req;

  int errors = 0;
  int checks = 0;
  int since  = 0;

  always #5 clk = ~clk;

  wdog_prescaled #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    since++;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    since++;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick();
    wr(8'h0A, 8'h1E);
    wr(8'h0A, 8'hE1);
    since = 0;
  endtask

  function automatic int period(input int e);
    return 1 << (CW + e);
  endfunction

  // waits for a request, checks its timing and that it lasts one cycle
  task automatic wait_req(input int p, input string tag);
    do tick(); while (!rst_req && since < p + 4);
    chk(rst_req && since == p, tag, since, p);
    since = 0;
    tick();
    chk(!rst_req, "R3 pulse width", int'(rst_req), 0);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (rst_req) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!rst_req, "R1 reset low", int'(rst_req), 0);
    rst_n = 1'b1;
    since = 0;
    // R1: default exponent 0
    wait_req(period(0), "R1 first period after reset");

    // vector table: R2 period per exponent, R3 restart
    for (int v = 0; v < NV; v++) begin
      wr(8'h0D, 8'(VEC_EXP[v]));
      kick();
      wait_req(period(VEC_EXP[v]), "R2 period");
      wait_req(period(VEC_EXP[v]), "R3 restart period");
    end

    // R5: broken sequences do not service
    wr(8'h0D, 8'h00);
    kick();
    wr(8'h0A, 8'hE1);
    wr(8'h0A, 8'h1E); wr(8'h0A, 8'h55); wr(8'h0A, 8'hE1);
    wr(8'h0A, 8'h1E); wr(8'h0C, 8'h00); wr(8'h0A, 8'hE1);
    wait_req(period(0), "R5 ignored sequences");

    // R4: valid clear mid-period restarts the period
    kick();
    repeat (period(0) / 2) tick();
    kick();
    wait_req(period(0), "R4 clear restarts");

    // R8: clear lands on the overflowing edge
    kick();
    while (since < period(0) - 2) tick();
    wr(8'h0A, 8'h1E);
    wr(8'h0A, 8'hE1);
    chk(since == period(0), "R8 aligned", since, period(0));
    chk(!rst_req, "R8 no request", int'(rst_req), 0);
    since = 0;
    wait_req(period(0), "R8 full period after clear");

    // R6: disabled stays silent; R7: re-enable restarts from zero
    wr(8'h0D, 8'h83);
    quiet(2 * period(3), "R6 disabled");
    wr(8'h0D, 8'h03);
    since = 0;
    wait_req(period(3), "R7 re-enable period");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule